// File: doc/BRIEF.md
# Aliased Shared FIFO Window

This block is the bus-facing front end of a crypto execution unit's data path. It owns two word-wide queues. The input queue carries words from the host bus toward the engine. The output queue carries engine results back to the host. Every address inside one aligned window is an alias for the same queue end. A write anywhere in the window appends a 64-bit word to the input queue, and a read anywhere in the window removes the oldest word from the output queue. The low address bits inside the window therefore select nothing.

The first write into the window claims the shared input queue for this unit by setting a reservation flag. Host errors are not lost silently. A write to a full input queue is dropped and latches an overflow flag. A read from an empty output queue returns zero and latches an underflow flag. Both flags and the reservation flag stay set until the host writes ones to a separate status address, or until reset. On the engine side, the block offers the input queue's head and accepts results into the output queue, each with a valid/ready handshake.

Top module: `shared_fifo_window`

## Requirements
- R1: A bus write to any address whose upper bits (above WIN_BITS) equal those of WIN_BASE appends busWdata to the input queue, whatever the low address bits are. Words leave in the order they were written.
- R2: A bus read from any address inside the window returns the oldest output-queue word on busRdata in the same cycle and removes it at the clock edge. Words leave in the order they were pushed.
- R3: Any bus write inside the window sets inReserved on the next clock edge.
- R4: A window write while inFull is high leaves the queue unchanged, with inCount staying DEPTH, and sets statOvf on the next edge. statOvf then holds until it is cleared.
- R5: A window read while outEmpty is high returns zero, leaves outCount at 0, and sets statUdf on the next edge. statUdf then holds until it is cleared.
- R6: A write to STAT_ADDR clears statOvf where busWdata bit 0 is 1, statUdf where bit 1 is 1, and inReserved where bit 2 is 1. Flags whose bit is 0 keep their value. Reset clears all three flags.
- R7: inPopValid is high exactly when the input queue holds a word, and inPopData is its oldest word. A cycle with inPopValid and inPopReady both high removes that word.
- R8: outPushReady is high exactly when the output queue is not full. A cycle with outPushValid and outPushReady both high appends outPushData. While the queue is full, outPushValid has no effect.
- R9: inCount and outCount give the number of stored words (0 to DEPTH). Each queue's empty flag is high at 0 and its full flag is high at DEPTH. After reset both queues are empty.
- R10: A bus access to an address outside the window that is not STAT_ADDR changes no queue and no flag, and a read from such an address returns zero.
- R11: A read from STAT_ADDR returns statOvf in bit 0, statUdf in bit 1 and inReserved in bit 2, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| inPopValid | output | 1 | Input queue has a word for the engine |
| inPopReady | input | 1 | Engine takes the input queue head |
| inPopData | output | DATA_W | Input queue head |
| outPushValid | input | 1 | Engine offers a result word |
| outPushReady | output | 1 | Output queue can accept a word |
| outPushData | input | DATA_W | Result word from the engine |
| inCount | output | CNT_W | Words in the input queue |
| outCount | output | CNT_W | Words in the output queue |
| inFull | output | 1 | Input queue full |
| inEmpty | output | 1 | Input queue empty |
| outFull | output | 1 | Output queue full |
| outEmpty | output | 1 | Output queue empty |
| statOvf | output | 1 | Sticky input overflow flag |
| statUdf | output | 1 | Sticky output underflow flag |
| inReserved | output | 1 | Input queue claimed by this unit |

## Verification
The properties assume that the address, direction and data inputs hold steady through each cycle in which busValid is high, and that busValid is never high during reset. The count-step properties also assume that a cycle does not combine an engine pop with a window write, or an engine push with a window read, because those cycles are left out of the step checks. The bench meets these assumptions. It changes every input only on the falling clock edge. It issues one bus access per cycle and keeps engine handshakes and bus queue accesses in separate cycles.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  // Source selected for the bus read data in the current cycle.
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_FIFO = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  // Strobes that the control issues to the datapath each cycle.
  typedef struct packed {
    logic   inPush;
    logic   inPop;
    logic   outPush;
    logic   outPop;
    rdSel_e rdSel;
  } ctrlStrb_t;

  localparam int STAT_OVF_BIT = 0;
  localparam int STAT_UDF_BIT = 1;
  localparam int STAT_RES_BIT = 2;

endpackage

// File: rtl/sfw_fifo.sv
module sfw_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);

  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wrPtr] <= wData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) begin
        wrPtr <= stepPtr(wrPtr);
      end
      if (pop) begin
        rdPtr <= stepPtr(rdPtr);
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rData = mem[rdPtr];
  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign count = cnt;

endmodule

// File: rtl/sfw_datapath.sv
module sfw_datapath
  import sfw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] outPushData,
  input  logic              ovfFlag,
  input  logic              udfFlag,
  input  logic              resFlag,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] inHead,
  output logic              inFull,
  output logic              inEmpty,
  output logic [CNT_W-1:0]  inCount,
  output logic              outFull,
  output logic              outEmpty,
  output logic [CNT_W-1:0]  outCount
);

  logic [DATA_W-1:0] outHead;
  logic [DATA_W-1:0] statWord;

  // Host to engine queue.
  sfw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_inFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strb.inPush),
    .pop   (strb.inPop),
    .wData (busWdata),
    .rData (inHead),
    .full  (inFull),
    .empty (inEmpty),
    .count (inCount)
  );

  // Engine to host queue.
  sfw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_outFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strb.outPush),
    .pop   (strb.outPop),
    .wData (outPushData),
    .rData (outHead),
    .full  (outFull),
    .empty (outEmpty),
    .count (outCount)
  );

  always_comb begin
    statWord               = '0;
    statWord[STAT_OVF_BIT] = ovfFlag;
    statWord[STAT_UDF_BIT] = udfFlag;
    statWord[STAT_RES_BIT] = resFlag;
  end

  always_comb begin
    case (strb.rdSel)
      RD_FIFO: busRdata = outHead;
      RD_STAT: busRdata = statWord;
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/sfw_control.sv
module sfw_control
  import sfw_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        clrBits,
  input  logic              inFull,
  input  logic              inEmpty,
  input  logic              outFull,
  input  logic              outEmpty,
  input  logic              inPopReady,
  input  logic              outPushValid,
  output ctrlStrb_t         strb,
  output logic              ovfFlag,
  output logic              udfFlag,
  output logic              resFlag
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  logic inWin;
  logic statHit;
  logic winWr;
  logic winRd;
  logic statWr;
  logic statRd;
  logic setOvf;
  logic setUdf;

  assign inWin   = (busAddr[ADDR_W-1:WIN_BITS] == WIN_TAG);
  assign statHit = (busAddr == STAT_ADDR);
  assign winWr   = busValid &  busWrite & inWin;
  assign winRd   = busValid & ~busWrite & inWin;
  assign statWr  = busValid &  busWrite & statHit & ~inWin;
  assign statRd  = busValid & ~busWrite & statHit & ~inWin;
  assign setOvf  = winWr & inFull;
  assign setUdf  = winRd & outEmpty;

  always_comb begin
    strb.inPush  = winWr & ~inFull;
    strb.inPop   = inPopReady & ~inEmpty;
    strb.outPush = outPushValid & ~outFull;
    strb.outPop  = winRd & ~outEmpty;
    if (statRd) begin
      strb.rdSel = RD_STAT;
    end else if (winRd && !outEmpty) begin
      strb.rdSel = RD_FIFO;
    end else begin
      strb.rdSel = RD_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
      resFlag <= 1'b0;
    end else begin
      if (setOvf) begin
        ovfFlag <= 1'b1;
      end else if (statWr && clrBits[STAT_OVF_BIT]) begin
        ovfFlag <= 1'b0;
      end
      if (setUdf) begin
        udfFlag <= 1'b1;
      end else if (statWr && clrBits[STAT_UDF_BIT]) begin
        udfFlag <= 1'b0;
      end
      if (winWr) begin
        resFlag <= 1'b1;
      end else if (statWr && clrBits[STAT_RES_BIT]) begin
        resFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/shared_fifo_window.sv
module shared_fifo_window
  import sfw_pkg::*;
#(
  parameter int                DATA_W    = 64,
  parameter int                DEPTH     = 8,
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0100,
  localparam int               CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              inPopValid,
  input  logic              inPopReady,
  output logic [DATA_W-1:0] inPopData,
  input  logic              outPushValid,
  output logic              outPushReady,
  input  logic [DATA_W-1:0] outPushData,
  output logic [CNT_W-1:0]  inCount,
  output logic [CNT_W-1:0]  outCount,
  output logic              inFull,
  output logic              inEmpty,
  output logic              outFull,
  output logic              outEmpty,
  output logic              statOvf,
  output logic              statUdf,
  output logic              inReserved
);

  ctrlStrb_t strb;

  sfw_control #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .WIN_BASE  (WIN_BASE),
    .STAT_ADDR (STAT_ADDR)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .clrBits      (busWdata[2:0]),
    .inFull       (inFull),
    .inEmpty      (inEmpty),
    .outFull      (outFull),
    .outEmpty     (outEmpty),
    .inPopReady   (inPopReady),
    .outPushValid (outPushValid),
    .strb         (strb),
    .ovfFlag      (statOvf),
    .udfFlag      (statUdf),
    .resFlag      (inReserved)
  );

  sfw_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .outPushData (outPushData),
    .ovfFlag     (statOvf),
    .udfFlag     (statUdf),
    .resFlag     (inReserved),
    .busRdata    (busRdata),
    .inHead      (inPopData),
    .inFull      (inFull),
    .inEmpty     (inEmpty),
    .inCount     (inCount),
    .outFull     (outFull),
    .outEmpty    (outEmpty),
    .outCount    (outCount)
  );

  assign inPopValid   = ~inEmpty;
  assign outPushReady = ~outFull;

endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int                DATA_W    = 64,
  parameter int                DEPTH     = 8,
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0100,
  localparam int               CNT_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              inPopValid,
  input logic              inPopReady,
  input logic              outPushValid,
  input logic              outPushReady,
  input logic [CNT_W-1:0]  inCount,
  input logic [CNT_W-1:0]  outCount,
  input logic              inFull,
  input logic              outEmpty,
  input logic              statOvf,
  input logic              statUdf,
  input logic              inReserved
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic winHit;
  logic statHit;
  logic winWr;
  logic winRd;
  logic engPop;
  logic engPush;

  assign winHit  = (busAddr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign statHit = (busAddr == STAT_ADDR);
  assign winWr   = busValid && busWrite && winHit;
  assign winRd   = busValid && !busWrite && winHit;
  assign engPop  = inPopValid && inPopReady;
  assign engPush = outPushValid && outPushReady;

  // R3
  reserve_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    winWr |=> inReserved);

  // R4
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winWr && inFull) |=> statOvf);

  // R4
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winWr && inFull && !engPop) |=> (inCount == FULL_CNT));

  // R5
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && outEmpty) |=> statUdf);

  // R5
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && outEmpty) |-> (busRdata == '0));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statOvf && !(busValid && busWrite && statHit && busWdata[0])) |=> statOvf);

  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statUdf && !(busValid && busWrite && statHit && busWdata[1])) |=> statUdf);

  // R7
  engine_pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engPop && !winWr) |=> (inCount == $past(inCount) - CNT_W'(1)));

  // R8
  engine_push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engPush && !winRd) |=> (outCount == $past(outCount) + CNT_W'(1)));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCount <= FULL_CNT) && (outCount <= FULL_CNT));

  // R10
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !winHit && !statHit && !engPop && !engPush)
      |=> ($stable(inCount) && $stable(outCount)));

endmodule

bind shared_fifo_window sfw_checker u_sfwChk (
  .clk          (clk),
  .rstN         (rstN),
  .busValid     (busValid),
  .busWrite     (busWrite),
  .busAddr      (busAddr),
  .busWdata     (busWdata),
  .busRdata     (busRdata),
  .inPopValid   (inPopValid),
  .inPopReady   (inPopReady),
  .outPushValid (outPushValid),
  .outPushReady (outPushReady),
  .inCount      (inCount),
  .outCount     (outCount),
  .inFull       (inFull),
  .outEmpty     (outEmpty),
  .statOvf      (statOvf),
  .statUdf      (statUdf),
  .inReserved   (inReserved)
);

// File: tb/shared_fifo_window_bench.sv
module shared_fifo_window_bench;

  localparam int              DATA_W    = 64;
  localparam int              DEPTH     = 8;
  localparam int              ADDR_W    = 16;
  localparam int              CNT_W     = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] WIN_BASE  = 16'h4000;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'h0100;
  localparam logic [ADDR_W-1:0] OUTSIDE   = 16'h8010;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              inPopValid;
  logic              inPopReady = 1'b0;
  logic [DATA_W-1:0] inPopData;
  logic              outPushValid = 1'b0;
  logic              outPushReady;
  logic [DATA_W-1:0] outPushData = '0;
  logic [CNT_W-1:0]  inCount;
  logic [CNT_W-1:0]  outCount;
  logic              inFull;
  logic              inEmpty;
  logic              outFull;
  logic              outEmpty;
  logic              statOvf;
  logic              statUdf;
  logic              inReserved;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] inQ[$];
  logic [DATA_W-1:0] outQ[$];
  logic expOvf = 1'b0;
  logic expUdf = 1'b0;
  logic expRes = 1'b0;

  always #10 clk = ~clk;

  shared_fifo_window u_shared_fifo_window (
    .clk          (clk),
    .rstN         (rstN),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .inPopValid   (inPopValid),
    .inPopReady   (inPopReady),
    .inPopData    (inPopData),
    .outPushValid (outPushValid),
    .outPushReady (outPushReady),
    .outPushData  (outPushData),
    .inCount      (inCount),
    .outCount     (outCount),
    .inFull       (inFull),
    .inEmpty      (inEmpty),
    .outFull      (outFull),
    .outEmpty     (outEmpty),
    .statOvf      (statOvf),
    .statUdf      (statUdf),
    .inReserved   (inReserved)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic inWindow(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:12] == WIN_BASE[ADDR_W-1:12];
  endfunction

  // Driver: one bus write, expected queue and flags updated from the requirements.
  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    if (inWindow(a)) begin
      expRes = 1'b1;
      if (inQ.size() < DEPTH) inQ.push_back(d);
      else expOvf = 1'b1;
    end else if (a == STAT_ADDR) begin
      if (d[0]) expOvf = 1'b0;
      if (d[1]) expUdf = 1'b0;
      if (d[2]) expRes = 1'b0;
    end
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // Bus read with the data checked in the access cycle.
  task automatic busRd(input string req, input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] exp;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    exp = '0;
    if (inWindow(a)) begin
      if (outQ.size() > 0) exp = outQ.pop_front();
      else expUdf = 1'b1;
    end else if (a == STAT_ADDR) begin
      exp = {61'd0, expRes, expUdf, expOvf};
    end
    #2;
    check(req, busRdata, exp);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic engPop();
    @(negedge clk);
    inPopReady = 1'b1;
    @(negedge clk);
    inPopReady = 1'b0;
  endtask

  task automatic engPush(input logic [DATA_W-1:0] d);
    @(negedge clk);
    check("R8 outPushReady", {63'd0, outPushReady}, {63'd0, outQ.size() < DEPTH});
    outPushValid = 1'b1; outPushData = d;
    if (outQ.size() < DEPTH) outQ.push_back(d);
    @(negedge clk);
    outPushValid = 1'b0;
  endtask

  task automatic chkState(input string req);
    #1;
    check({req, " inCount"}, {60'd0, inCount}, 64'(inQ.size()));
    check({req, " outCount"}, {60'd0, outCount}, 64'(outQ.size()));
    check({req, " flags"},
          {56'd0, inFull, inEmpty, outFull, outEmpty, inPopValid, statOvf, statUdf, inReserved},
          {56'd0, inQ.size() == DEPTH, inQ.size() == 0, outQ.size() == DEPTH,
           outQ.size() == 0, inQ.size() != 0, expOvf, expUdf, expRes});
  endtask

  // Monitor: every engine pop handshake is compared with the oldest expected word (R7, R1).
  always @(negedge clk) begin
    #1;
    if (rstN && inPopReady && inPopValid) begin
      if (inQ.size() == 0) begin
        check("R7 pop with nothing expected", inPopData, '1);
      end else begin
        check("R1 R7 engine word order", inPopData, inQ.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chkState("R9 reset");
    rstN = 1'b1;
    @(negedge clk);
    chkState("R9 after reset");

    // R1 aliased writes, R3 reservation
    busWr(WIN_BASE, 64'h1111_0000_0000_0001);
    busWr(WIN_BASE + 16'h0008, 64'h2222_0000_0000_0002);
    busWr(WIN_BASE + 16'h0FFF, 64'h3333_0000_0000_0003);
    chkState("R1 R3 after window writes");
    busRd("R11 status read", STAT_ADDR);

    // R7 engine drains in order; empty pop has no effect
    repeat (3) engPop();
    chkState("R7 drained");
    engPop();
    chkState("R7 pop on empty");

    // R4 fill then overflow
    for (int i = 0; i < DEPTH; i++) busWr(WIN_BASE + 16'(i * 24), 64'hA000 + 64'(i));
    chkState("R9 input full");
    busWr(WIN_BASE + 16'h0100, 64'hDEAD_BEEF);
    chkState("R4 overflow");
    for (int i = 0; i < DEPTH; i++) engPop();
    chkState("R4 drained after overflow");

    // R6 selective clear
    busWr(STAT_ADDR, 64'h1);
    chkState("R6 clear ovf only");
    busRd("R11 status after clear", STAT_ADDR);
    busWr(STAT_ADDR, 64'h4);
    chkState("R6 clear reservation");

    // R2 engine results read from aliased addresses
    engPush(64'h0B0B_0001);
    engPush(64'h0B0B_0002);
    engPush(64'h0B0B_0003);
    busRd("R2 read word 1", WIN_BASE + 16'h0010);
    busRd("R2 read word 2", WIN_BASE + 16'h0AA8);
    busRd("R2 read word 3", WIN_BASE);
    chkState("R2 output drained");

    // R5 underflow
    busRd("R5 empty read returns zero", WIN_BASE + 16'h0040);
    chkState("R5 underflow");
    busRd("R11 status with underflow", STAT_ADDR);
    busWr(STAT_ADDR, 64'h2);
    chkState("R6 clear udf");

    // R8 fill output then attempt extra push
    for (int i = 0; i < DEPTH; i++) engPush(64'hC000 + 64'(i));
    chkState("R8 output full");
    engPush(64'hFFFF_FFFF);
    chkState("R8 push while full ignored");

    // R10 outside the window
    busWr(OUTSIDE, 64'h7);
    chkState("R10 outside write");
    busRd("R10 outside read zero", OUTSIDE);
    chkState("R10 outside read");

    for (int i = 0; i < DEPTH; i++) busRd("R2 drain full output", WIN_BASE + 16'(i * 8));
    chkState("R9 end");

    // Reset clears flags (R6)
    busRd("R5 second underflow", WIN_BASE);
    busWr(WIN_BASE, 64'h55);
    @(negedge clk);
    rstN = 1'b0;
    inQ.delete(); outQ.delete();
    expOvf = 1'b0; expUdf = 1'b0; expRes = 1'b0;
    @(negedge clk);
    chkState("R6 reset clears flags");
    rstN = 1'b1;

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule